// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of a memory burst. A mode key is loaded first; it sets the burst length, the beat ordering (sequential or interleaved), the column-access latency and a mode in which write bursts shrink to one beat. When a read or write command is accepted, the block captures the starting column. From the next clock on it presents one column address per beat. The burst runs until its programmed length is used up, or until a burst-stop, a terminate or a new command cuts it short.

The column output is a stream: `col_valid` marks a presented beat and `out_ready` accepts it. A beat is consumed on a clock edge where both are high. While `out_ready` is low, the presented address and `col_valid` hold and the beat count does not advance. Back-pressure never delays `start`, `burst_stop` or `terminate`, which act on the edge where they are sampled. The latency and error outputs are plain levels taken from the loaded key.

Top module: `burst_col_gen`

## Requirements
- R1: Key bits 2:0 select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8. With key bit 3 at 0 the ordering is sequential and wraps inside the aligned block of that length: length 4 from low bits 1 gives 1,2,3,0, and length 8 from low bits 5 gives 5,6,7,0,1,2,3,4.
- R2: With key bit 3 at 1 the ordering is interleaved: the low bits of beat k are the start low bits XOR k. Length 8 from low bits 3 gives 3,2,1,0,7,6,5,4.
- R3: Key bits 2:0 at 111 with key bit 3 at 0 select a full-row burst. It steps sequentially through all 2^COL_W columns, wrapping from the top column to 0. It never raises `col_last` and continues until a burst-stop or a terminate.
- R4: With key bit 9 set, a burst started with `start_write` high has exactly one beat. A burst started with `start_write` low keeps the programmed length.
- R5: Key bits 6:4 give `cas_lat`: 001 gives 1, 010 gives 2, 011 gives 3. Every other code gives 0.
- R6: A load whose key has bit 10, bit 8 or bit 7 set is ignored: length, ordering, latency and single-write mode all keep their earlier values.
- R7: Length codes 100, 101 and 110, and code 111 with key bit 3 at 1, raise `mode_err` while loaded, and every burst then has one beat. The next legal load clears `mode_err`.
- R8: `burst_stop` ends a burst of any length: `col_valid` is low from the next clock.
- R9: `terminate` ends the burst from the next clock and wins over a `start` sampled on the same edge.
- R10: A `start` during an active burst drops the old burst. The new burst's first address appears on the next clock.
- R11: Address bits above the burst block keep their start values for the whole burst.
- R12: `start` is sampled on a clock edge and the first beat, equal to `start_col`, is presented from the next clock. `col_last` is high only on the final beat of a finite burst. `col_valid` falls after the final beat is accepted.
- R13: While `out_ready` is low, `col_valid` and `col_addr` hold and no beat is consumed.
- R14: After reset `col_valid`, `col_last` and `mode_err` are 0, `cas_lat` is 0, and the mode is length 1, sequential, with single-write mode off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load `mode_key` into the mode register |
| mode_key | input | 11 | Mode key |
| start | input | 1 | Accept a read or write command |
| start_write | input | 1 | The accepted command is a write |
| start_col | input | COL_W (8) | Starting column |
| burst_stop | input | 1 | End the current burst |
| terminate | input | 1 | Abort the burst (highest priority) |
| out_ready | input | 1 | Consumer accepts the presented beat |
| col_addr | output | COL_W (8) | Column address of the presented beat |
| col_valid | output | 1 | A beat is presented |
| col_last | output | 1 | Presented beat is the last of a finite burst |
| cas_lat | output | 2 | Decoded latency, 0 for reserved codes |
| mode_err | output | 1 | Loaded length setting is reserved |

## Verification
The bench builds the block with COL_W at 8. A full-row burst is then 256 beats, and a run of 260 beats crosses the wrap from column 255 back to 0 and observes that no last flag appears. With five address bits above the widest finite block, starting columns such as 0x93 and 0x25 show that the upper bits are held while the low bits wrap or are XOR-permuted.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int KEY_W = 11;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic [2:0] lat_code;
    logic       wr_single;
  } mode_t;
endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output mode_t            mode_q
);
  logic rfu_set;
  assign rfu_set = key[10] | key[8] | key[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (load && !rfu_set) begin
      mode_q.len_code  <= key[2:0];
      mode_q.ilv       <= key[3];
      mode_q.lat_code  <= key[6:4];
      mode_q.wr_single <= key[9];
    end
  end

  AST_RFU_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    load && rfu_set |=> $stable(mode_q)); // R6
endmodule

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  mode_t            mode,
  input  logic             is_write,
  output logic [COL_W-1:0] mask,
  output logic             full_page,
  output logic             ilv,
  output logic             err,
  output logic [1:0]       lat
);
  always_comb begin
    mask      = '0;
    full_page = 1'b0;
    err       = 1'b0;
    unique case (mode.len_code)
      3'b000: mask = COL_W'(0);
      3'b001: mask = COL_W'(1);
      3'b010: mask = COL_W'(3);
      3'b011: mask = COL_W'(7);
      3'b111: begin
        if (mode.ilv) begin
          err = 1'b1;
        end else begin
          mask      = '1;
          full_page = 1'b1;
        end
      end
      default: err = 1'b1;
    endcase
    if (mode.wr_single && is_write) begin
      mask      = '0;
      full_page = 1'b0;
    end
    ilv = mode.ilv & ~full_page;
  end

  always_comb begin
    unique case (mode.lat_code)
      3'b001:  lat = 2'd1;
      3'b010:  lat = 2'd2;
      3'b011:  lat = 2'd3;
      default: lat = 2'd0;
    endcase
  end
endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low;
  assign low = ilv ? (base ^ beat) : (base + beat);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr[b] = mask[b] ? low[b] : base[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             start,
  input  logic             start_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  input  logic             terminate,
  input  logic             out_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic             mode_err
);
  mode_t            mode_q;
  logic [COL_W-1:0] dec_mask;
  logic             dec_fp;
  logic             dec_ilv;

  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             fp_q;
  logic             ilv_q;
  logic             final_beat;

  bcg_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mode_load),
    .key    (mode_key),
    .mode_q (mode_q)
  );

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .mode      (mode_q),
    .is_write  (start_write),
    .mask      (dec_mask),
    .full_page (dec_fp),
    .ilv       (dec_ilv),
    .err       (mode_err),
    .lat       (cas_lat)
  );

  assign final_beat = active_q && !fp_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      fp_q     <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (terminate) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col;
      mask_q   <= dec_mask;
      fp_q     <= dec_fp;
      ilv_q    <= dec_ilv;
    end else if (burst_stop) begin
      active_q <= 1'b0;
    end else if (active_q && out_ready) begin
      if (final_beat) active_q <= 1'b0;
      else            beat_q   <= beat_q + 1'b1;
    end
  end

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_q),
    .ilv  (ilv_q),
    .addr (col_addr)
  );

  assign col_valid = active_q;
  assign col_last  = final_beat;

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start && !terminate |=> col_valid && (col_addr == $past(start_col))); // R12
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R12
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && out_ready && !start && !terminate |=> !col_valid); // R12
  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop && !start && !terminate |=> !col_valid); // R8
  AST_TERM_END: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |=> !col_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !out_ready && !start && !terminate && !burst_stop
    |=> col_valid && $stable(col_addr)); // R13
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !fp_q && $past(col_valid) && !$past(start)
    |-> col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])); // R11
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start && !terminate && mode_err |=> col_last); // R7
  AST_FP_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> !col_last); // R3
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        mode_load;
  logic [10:0] mode_key;
  logic        start;
  logic        start_write;
  logic [7:0]  start_col;
  logic        burst_stop;
  logic        terminate;
  logic        out_ready;
  logic [7:0]  col_addr;
  logic        col_valid;
  logic        col_last;
  logic [1:0]  cas_lat;
  logic        mode_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  burst_col_gen #(.COL_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_key(mode_key),
    .start(start), .start_write(start_write), .start_col(start_col),
    .burst_stop(burst_stop), .terminate(terminate), .out_ready(out_ready),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
    .cas_lat(cas_lat), .mode_err(mode_err)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_mode(input logic [10:0] k);
    mode_load = 1'b1;
    mode_key  = k;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic start_b(input logic [7:0] col, input logic wr);
    start       = 1'b1;
    start_col   = col;
    start_write = wr;
    @(negedge clk);
    start       = 1'b0;
    start_write = 1'b0;
  endtask

  task automatic run_beats(input string req, input int seq[$]);
    foreach (seq[i]) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " addr"}, int'(col_addr), seq[i]);
      chk({req, " last"}, int'(col_last), (i == seq.size() - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " end"}, int'(col_valid), 0);
  endtask

  task automatic t_reset;
    chk("R14 valid", int'(col_valid), 0);
    chk("R14 last", int'(col_last), 0);
    chk("R14 cas", int'(cas_lat), 0);
    chk("R14 err", int'(mode_err), 0);
    start_b(8'h6A, 1'b0);
    run_beats("R14 len1", '{8'h6A});
  endtask

  task automatic t_seq;
    load_mode(11'h032);
    chk("R5 cas3", int'(cas_lat), 3);
    start_b(8'h41, 1'b0);
    run_beats("R1 R11 R12 bl4", '{8'h41, 8'h42, 8'h43, 8'h40});
    load_mode(11'h033);
    start_b(8'h25, 1'b1);
    run_beats("R1 R11 bl8", '{8'h25, 8'h26, 8'h27, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24});
    load_mode(11'h021);
    chk("R5 cas2", int'(cas_lat), 2);
    start_b(8'h0F, 1'b0);
    run_beats("R1 bl2", '{8'h0F, 8'h0E});
  endtask

  task automatic t_ilv;
    load_mode(11'h02B);
    start_b(8'h93, 1'b0);
    run_beats("R2 R11 ilv8", '{8'h93, 8'h92, 8'h91, 8'h90, 8'h97, 8'h96, 8'h95, 8'h94});
    load_mode(11'h02A);
    start_b(8'hC1, 1'b0);
    run_beats("R2 ilv4", '{8'hC1, 8'hC0, 8'hC3, 8'hC2});
  endtask

  task automatic t_fullpage;
    load_mode(11'h017);
    chk("R5 cas1", int'(cas_lat), 1);
    start_b(8'hFE, 1'b0);
    for (int i = 0; i < 260; i++) begin
      chk("R3 fp valid", int'(col_valid), 1);
      chk("R3 fp addr", int'(col_addr), (254 + i) % 256);
      chk("R3 fp last", int'(col_last), 0);
      @(negedge clk);
    end
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R3 R8 fp stopped", int'(col_valid), 0);
  endtask

  task automatic t_wr_single;
    load_mode(11'h232);
    start_b(8'h50, 1'b1);
    run_beats("R4 write", '{8'h50});
    start_b(8'h52, 1'b0);
    run_beats("R4 read", '{8'h52, 8'h53, 8'h50, 8'h51});
  endtask

  task automatic t_rfu;
    load_mode(11'h032);
    load_mode(11'h113);
    chk("R6 bit8 cas", int'(cas_lat), 3);
    load_mode(11'h413);
    chk("R6 bit10 cas", int'(cas_lat), 3);
    load_mode(11'h09B);
    chk("R6 bit7 cas", int'(cas_lat), 3);
    start_b(8'h09, 1'b0);
    run_beats("R6 len kept", '{8'h09, 8'h0A, 8'h0B, 8'h08});
    load_mode(11'h052);
    chk("R5 reserved cas", int'(cas_lat), 0);
  endtask

  task automatic t_err;
    load_mode(11'h034);
    chk("R7 err code100", int'(mode_err), 1);
    start_b(8'h37, 1'b0);
    run_beats("R7 len1", '{8'h37});
    load_mode(11'h01F);
    chk("R7 err fp ilv", int'(mode_err), 1);
    start_b(8'h80, 1'b0);
    run_beats("R7 fp ilv len1", '{8'h80});
    load_mode(11'h032);
    chk("R7 err cleared", int'(mode_err), 0);
  endtask

  task automatic t_stop;
    load_mode(11'h033);
    start_b(8'h00, 1'b0);
    chk("R8 beat0", int'(col_addr), 0);
    @(negedge clk);
    chk("R8 beat1", int'(col_addr), 1);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R8 stopped", int'(col_valid), 0);
  endtask

  task automatic t_terminate;
    load_mode(11'h033);
    start_b(8'h00, 1'b0);
    chk("R9 beat0", int'(col_valid), 1);
    terminate = 1'b1;
    start     = 1'b1;
    start_col = 8'h44;
    @(negedge clk);
    terminate = 1'b0;
    start     = 1'b0;
    chk("R9 terminated", int'(col_valid), 0);
    @(negedge clk);
    chk("R9 still idle", int'(col_valid), 0);
  endtask

  task automatic t_restart;
    load_mode(11'h033);
    start_b(8'h00, 1'b0);
    @(negedge clk);
    chk("R10 old beat1", int'(col_addr), 1);
    start_b(8'h15, 1'b0);
    run_beats("R10 new", '{8'h15, 8'h16, 8'h17, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14});
  endtask

  task automatic t_stall;
    load_mode(11'h032);
    start_b(8'h10, 1'b0);
    chk("R13 beat0", int'(col_addr), 8'h10);
    @(negedge clk);
    chk("R13 beat1", int'(col_addr), 8'h11);
    out_ready = 1'b0;
    @(negedge clk);
    chk("R13 hold valid", int'(col_valid), 1);
    chk("R13 hold addr", int'(col_addr), 8'h11);
    @(negedge clk);
    chk("R13 hold addr2", int'(col_addr), 8'h11);
    out_ready = 1'b1;
    @(negedge clk);
    run_beats("R13 resume", '{8'h12, 8'h13});
  endtask

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_key = '0; start = 1'b0;
    start_write = 1'b0; start_col = '0; burst_stop = 1'b0;
    terminate = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seq();
    t_ilv();
    t_fullpage();
    t_wr_single();
    t_rfu();
    t_err();
    t_stop();
    t_terminate();
    t_restart();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule